// File: doc/BRIEF.md
# Shift and Rotate Execution Unit

This unit computes the result of the integer shift and rotate operations of a 64-bit processor pipeline. A decoded operation code picks the data width (32-bit word or 64-bit doubleword), the direction (left, logical right, arithmetic right) and the amount source. The amount comes from the 5-bit immediate field, from that field plus 32, or from the low bits of a second register operand.

Rotate-right has no operation code of its own. On the fixed-amount logical right operations, the otherwise-unused register-select field chooses between shift and rotate. On the variable-amount logical right operations, the immediate field makes that choice. Unsupported values of the register-select field, and the single reserved operation code, raise an illegal flag and force the result to zero. Every 32-bit result is sign-extended from bit 31.

The result and the flag are registered, so both appear one clock after the inputs are presented. A synchronous active-high reset clears both.

Top module: `shrot_unit`

## Requirements
- R1: A high `rst` on a rising clock edge clears `out_res` and `out_bad`. Otherwise both outputs show, one rising edge later, the result of the inputs present at that edge.
- R2: Code 0 shifts the low 32 bits of `in_rt` left by `in_sa_fld`. Code 3 shifts them left by `in_rs[4:0]`. The 32-bit result is sign-extended from bit 31.
- R3: For code 1 (fixed 32-bit logical right), `in_rs_fld`=0 shifts the low 32 bits of `in_rt` right by `in_sa_fld` with zero fill, and `in_rs_fld`=1 rotates them right by `in_sa_fld`. Either result is sign-extended from bit 31.
- R4: Code 2 (amount `in_sa_fld`) and code 5 (amount `in_rs[4:0]`) shift the low 32 bits of `in_rt` right, filling from bit 31. The result is sign-extended.
- R5: Code 6 shifts the 64-bit `in_rt` left by `in_sa_fld`. Code 9 shifts it left by `in_sa_fld`+32. Code 12 shifts it left by `in_rs[5:0]`.
- R6: For code 7 the amount is `in_sa_fld`, and for code 10 it is `in_sa_fld`+32. With either code, `in_rs_fld`=0 gives a 64-bit logical right shift of `in_rt` and `in_rs_fld`=1 gives a 64-bit rotate right.
- R7: Codes 8 (amount `in_sa_fld`), 11 (amount `in_sa_fld`+32) and 14 (amount `in_rs[5:0]`) shift `in_rt` right, filling from bit 63.
- R8: Codes 4 (32-bit, amount `in_rs[4:0]`) and 13 (64-bit, amount `in_rs[5:0]`) perform a logical right shift when `in_sa_fld`=0 and a rotate right when it is nonzero. The 32-bit form is sign-extended. Higher bits of `in_rs` have no effect.
- R9: `in_rs_fld` greater than 1 on code 1, 7 or 10, or operation code 15, sets `out_bad` and forces `out_res` to zero. All other inputs leave `out_bad` clear.
- R10: An effective amount of zero returns `in_rt` unchanged for 64-bit operations, or its low 32 bits sign-extended for 32-bit operations.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_op | input | 4 | Decoded operation code (0 to 15) |
| in_sa_fld | input | 5 | Immediate amount field; selects rotate on codes 4 and 13 |
| in_rs_fld | input | 5 | Register-select field; selects shift or rotate on codes 1, 7 and 10 |
| in_rt | input | 64 | Value to shift or rotate |
| in_rs | input | 64 | Variable amount operand |
| out_res | output | 64 | Registered result |
| out_bad | output | 1 | Registered illegal-encoding flag |

## Verification
The assertions assume that reset is applied during the first clock cycles and that the inputs are stable and known at each rising edge. Under those conditions they can relate each registered output to the inputs one edge earlier. The stimulus drives every input on the falling edge, so each value is settled before the next rising edge. The random mix draws `in_rs_fld` mostly from 0 and 1 and only sometimes from the full range, so both the legal paths and the illegal-field path are exercised.

// File: rtl/shrot_pkg.sv
package shrot_pkg;

  typedef enum logic [3:0] {
    OP_SL_W    = 4'd0,
    OP_SR_W    = 4'd1,
    OP_SA_W    = 4'd2,
    OP_SLV_W   = 4'd3,
    OP_SRV_W   = 4'd4,
    OP_SAV_W   = 4'd5,
    OP_SL_D    = 4'd6,
    OP_SR_D    = 4'd7,
    OP_SA_D    = 4'd8,
    OP_SL_D32  = 4'd9,
    OP_SR_D32  = 4'd10,
    OP_SA_D32  = 4'd11,
    OP_SLV_D   = 4'd12,
    OP_SRV_D   = 4'd13,
    OP_SAV_D   = 4'd14,
    OP_RSVD    = 4'd15
  } shrot_op_e;

  typedef enum logic [1:0] {
    SHM_LEFT = 2'd0,
    SHM_LOGR = 2'd1,
    SHM_ARIR = 2'd2,
    SHM_ROTR = 2'd3
  } shrot_mode_e;

endpackage

// File: rtl/shrot_decode.sv
module shrot_decode
  import shrot_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  logic [3:0]                  op,
  input  logic [$clog2(DATA_W)-2:0]   sa_fld,
  input  logic [$clog2(DATA_W)-2:0]   rs_fld,
  input  logic [$clog2(DATA_W)-1:0]   rs_amt,
  output logic [$clog2(DATA_W)-1:0]   amt,
  output shrot_mode_e                 mode,
  output logic                        is_word,
  output logic                        bad
);
  localparam int AMT_W = $clog2(DATA_W);
  localparam int FLD_W = AMT_W - 1;

  logic [AMT_W-1:0] fix_amt;
  logic [AMT_W-1:0] fix32_amt;
  logic [AMT_W-1:0] varw_amt;
  logic             rs_fld_bad;
  shrot_mode_e      fix_r_mode;
  shrot_mode_e      var_r_mode;

  assign fix_amt    = {1'b0, sa_fld};
  assign fix32_amt  = {1'b1, sa_fld};
  assign varw_amt   = {1'b0, rs_amt[FLD_W-1:0]};
  assign rs_fld_bad = (rs_fld > FLD_W'(1));
  assign fix_r_mode = (rs_fld == '0) ? SHM_LOGR : SHM_ROTR;
  assign var_r_mode = (sa_fld == '0) ? SHM_LOGR : SHM_ROTR;

  always_comb begin
    amt     = '0;
    mode    = SHM_LEFT;
    is_word = 1'b0;
    bad     = 1'b0;
    unique case (shrot_op_e'(op))
      OP_SL_W:   begin is_word = 1'b1; amt = fix_amt; mode = SHM_LEFT; end
      OP_SR_W:   begin is_word = 1'b1; amt = fix_amt; mode = fix_r_mode; bad = rs_fld_bad; end
      OP_SA_W:   begin is_word = 1'b1; amt = fix_amt; mode = SHM_ARIR; end
      OP_SLV_W:  begin is_word = 1'b1; amt = varw_amt; mode = SHM_LEFT; end
      OP_SRV_W:  begin is_word = 1'b1; amt = varw_amt; mode = var_r_mode; end
      OP_SAV_W:  begin is_word = 1'b1; amt = varw_amt; mode = SHM_ARIR; end
      OP_SL_D:   begin amt = fix_amt; mode = SHM_LEFT; end
      OP_SR_D:   begin amt = fix_amt; mode = fix_r_mode; bad = rs_fld_bad; end
      OP_SA_D:   begin amt = fix_amt; mode = SHM_ARIR; end
      OP_SL_D32: begin amt = fix32_amt; mode = SHM_LEFT; end
      OP_SR_D32: begin amt = fix32_amt; mode = fix_r_mode; bad = rs_fld_bad; end
      OP_SA_D32: begin amt = fix32_amt; mode = SHM_ARIR; end
      OP_SLV_D:  begin amt = rs_amt; mode = SHM_LEFT; end
      OP_SRV_D:  begin amt = rs_amt; mode = var_r_mode; end
      OP_SAV_D:  begin amt = rs_amt; mode = SHM_ARIR; end
      default:   begin bad = 1'b1; end
    endcase
  end
endmodule

// File: rtl/shrot_bitrev.sv
module shrot_bitrev #(
  parameter int DATA_W = 64
) (
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout
);
  for (genvar i = 0; i < DATA_W; i++) begin : g_rev
    assign dout[i] = din[DATA_W-1-i];
  end
endmodule

// File: rtl/shrot_core.sv
module shrot_core
  import shrot_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  logic [DATA_W-1:0]         rt_val,
  input  logic [$clog2(DATA_W)-1:0] amt,
  input  shrot_mode_e               mode,
  input  logic                      is_word,
  output logic [DATA_W-1:0]         res
);
  localparam int AMT_W  = $clog2(DATA_W);
  localparam int HALF_W = DATA_W / 2;

  logic [HALF_W-1:0] lo;
  logic [DATA_W-1:0] base;
  logic [DATA_W-1:0] base_rev;
  logic [DATA_W-1:0] src;
  logic [DATA_W-1:0] sh_out;
  logic [DATA_W-1:0] sh_rev;
  logic [DATA_W-1:0] full;
  logic              sgn;
  logic              rot;
  logic [DATA_W-1:0] stage [AMT_W+1];

  assign lo = rt_val[HALF_W-1:0];

  // Word-width sources are laid out so that one doubleword shifter serves all.
  always_comb begin
    unique case (mode)
      SHM_ROTR: base = is_word ? {lo, lo} : rt_val;
      SHM_ARIR: base = is_word ? {{HALF_W{lo[HALF_W-1]}}, lo} : rt_val;
      default:  base = is_word ? {{HALF_W{1'b0}}, lo} : rt_val;
    endcase
  end

  shrot_bitrev #(.DATA_W(DATA_W)) u_rev_in  (.din(base),   .dout(base_rev));
  shrot_bitrev #(.DATA_W(DATA_W)) u_rev_out (.din(sh_out), .dout(sh_rev));

  assign src      = (mode == SHM_LEFT) ? base_rev : base;
  assign sgn      = (mode == SHM_ARIR) & base[DATA_W-1];
  assign rot      = (mode == SHM_ROTR);
  assign stage[0] = src;

  for (genvar j = 0; j < AMT_W; j++) begin : g_stage
    localparam int D = 1 << j;
    logic [D-1:0] fill;
    assign fill = rot ? stage[j][D-1:0] : {D{sgn}};
    assign stage[j+1] = amt[j] ? {fill, stage[j][DATA_W-1:D]} : stage[j];
  end

  assign sh_out = stage[AMT_W];
  assign full   = (mode == SHM_LEFT) ? sh_rev : sh_out;
  assign res    = is_word ? {{HALF_W{full[HALF_W-1]}}, full[HALF_W-1:0]} : full;
endmodule

// File: rtl/shrot_unit.sv
module shrot_unit
  import shrot_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [3:0]                  in_op,
  input  logic [$clog2(DATA_W)-2:0]   in_sa_fld,
  input  logic [$clog2(DATA_W)-2:0]   in_rs_fld,
  input  logic [DATA_W-1:0]           in_rt,
  input  logic [DATA_W-1:0]           in_rs,
  output logic [DATA_W-1:0]           out_res,
  output logic                        out_bad
);
  localparam int AMT_W = $clog2(DATA_W);

  logic [AMT_W-1:0]  amt;
  shrot_mode_e       mode;
  logic              is_word;
  logic              bad;
  logic [DATA_W-1:0] core_res;
  logic              unused_rs_hi;

  assign unused_rs_hi = ^in_rs[DATA_W-1:AMT_W];

  shrot_decode #(.DATA_W(DATA_W)) u_dec (
    .op      (in_op),
    .sa_fld  (in_sa_fld),
    .rs_fld  (in_rs_fld),
    .rs_amt  (in_rs[AMT_W-1:0]),
    .amt     (amt),
    .mode    (mode),
    .is_word (is_word),
    .bad     (bad)
  );

  shrot_core #(.DATA_W(DATA_W)) u_core (
    .rt_val  (in_rt),
    .amt     (amt),
    .mode    (mode),
    .is_word (is_word),
    .res     (core_res)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_res <= '0;
      out_bad <= 1'b0;
    end else begin
      out_bad <= bad;
      out_res <= bad ? '0 : core_res;
    end
  end
endmodule

// File: rtl/shrot_chk.sv
module shrot_chk
  import shrot_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input logic                      clk,
  input logic                      rst,
  input logic [3:0]                in_op,
  input logic [$clog2(DATA_W)-2:0] in_sa_fld,
  input logic [$clog2(DATA_W)-2:0] in_rs_fld,
  input logic [DATA_W-1:0]         in_rt,
  input logic [DATA_W-1:0]         out_res,
  input logic                      out_bad
);
  localparam int HALF_W = DATA_W / 2;

  logic word_op;
  logic fixr_op;
  assign word_op = (in_op <= 4'd5);
  assign fixr_op = (in_op == OP_SR_W) || (in_op == OP_SR_D) || (in_op == OP_SR_D32);

  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (out_res == '0 && !out_bad));

  p_word_sext_r3: assert property (@(posedge clk) disable iff (rst)
    word_op |=> (out_res[DATA_W-1:HALF_W] == {HALF_W{out_res[HALF_W-1]}}));

  p_bad_zero_r9: assert property (@(posedge clk) disable iff (rst)
    out_bad |-> (out_res == '0));

  p_bad_field_r9: assert property (@(posedge clk) disable iff (rst)
    (fixr_op && in_rs_fld > 1) |=> out_bad);

  p_bad_op_r9: assert property (@(posedge clk) disable iff (rst)
    (in_op == OP_RSVD) |=> out_bad);

  p_left_ok_r9: assert property (@(posedge clk) disable iff (rst)
    (in_op == OP_SL_D) |=> !out_bad);

  p_zero_amt_r10: assert property (@(posedge clk) disable iff (rst)
    (in_op == OP_SL_D && in_sa_fld == '0) |=> (out_res == $past(in_rt)));
endmodule

bind shrot_unit shrot_chk #(.DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_op     (in_op),
  .in_sa_fld (in_sa_fld),
  .in_rs_fld (in_rs_fld),
  .in_rt     (in_rt),
  .out_res   (out_res),
  .out_bad   (out_bad)
);

// File: tb/shrot_unit_tb.sv
module shrot_unit_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  in_op = '0;
  logic [4:0]  in_sa_fld = '0;
  logic [4:0]  in_rs_fld = '0;
  logic [63:0] in_rt = '0;
  logic [63:0] in_rs = '0;
  logic [63:0] out_res;
  logic        out_bad;

  int n_chk = 0;
  int n_err = 0;

  always #5 clk = ~clk;

  shrot_unit u_dut (
    .clk(clk), .rst(rst), .in_op(in_op), .in_sa_fld(in_sa_fld),
    .in_rs_fld(in_rs_fld), .in_rt(in_rt), .in_rs(in_rs),
    .out_res(out_res), .out_bad(out_bad)
  );

  function automatic logic [31:0] rotr32(input logic [31:0] x, input int n);
    return (n == 0) ? x : ((x >> n) | (x << (32 - n)));
  endfunction

  function automatic logic [63:0] rotr64(input logic [63:0] x, input int n);
    return (n == 0) ? x : ((x >> n) | (x << (64 - n)));
  endfunction

  // Returns {bad, result}
  function automatic logic [64:0] ref_op(input logic [3:0] op, input logic [4:0] saf,
                                         input logic [4:0] rsf, input logic [63:0] rt,
                                         input logic [63:0] rs);
    logic [31:0]        w;
    logic signed [31:0] sw;
    logic signed [63:0] sd;
    logic [31:0]        r32;
    logic [63:0]        r64;
    logic               wd;
    logic               bad;
    int                 nf;
    int                 nv5;
    int                 nv6;
    w = rt[31:0]; sw = rt[31:0]; sd = rt;
    nf = int'(saf); nv5 = int'(rs[4:0]); nv6 = int'(rs[5:0]);
    r32 = '0; r64 = '0; wd = 1'b0; bad = 1'b0;
    case (op)
      4'd0:  begin wd = 1; r32 = w << nf; end
      4'd1:  begin wd = 1; if (rsf == 0) r32 = w >> nf; else if (rsf == 1) r32 = rotr32(w, nf); else bad = 1; end
      4'd2:  begin wd = 1; r32 = sw >>> nf; end
      4'd3:  begin wd = 1; r32 = w << nv5; end
      4'd4:  begin wd = 1; r32 = (saf == 0) ? (w >> nv5) : rotr32(w, nv5); end
      4'd5:  begin wd = 1; r32 = sw >>> nv5; end
      4'd6:  r64 = rt << nf;
      4'd7:  begin if (rsf == 0) r64 = rt >> nf; else if (rsf == 1) r64 = rotr64(rt, nf); else bad = 1; end
      4'd8:  r64 = sd >>> nf;
      4'd9:  r64 = rt << (nf + 32);
      4'd10: begin if (rsf == 0) r64 = rt >> (nf + 32); else if (rsf == 1) r64 = rotr64(rt, nf + 32); else bad = 1; end
      4'd11: r64 = sd >>> (nf + 32);
      4'd12: r64 = rt << nv6;
      4'd13: r64 = (saf == 0) ? (rt >> nv6) : rotr64(rt, nv6);
      4'd14: r64 = sd >>> nv6;
      default: bad = 1;
    endcase
    if (wd) r64 = {{32{r32[31]}}, r32};
    if (bad) r64 = '0;
    return {bad, r64};
  endfunction

  function automatic string tag_of(input logic [3:0] op, input logic bad);
    if (bad) return "R9";
    case (op)
      4'd0, 4'd3:          return "R2";
      4'd1:                return "R3";
      4'd2, 4'd5:          return "R4";
      4'd6, 4'd9, 4'd12:   return "R5";
      4'd7, 4'd10:         return "R6";
      4'd8, 4'd11, 4'd14:  return "R7";
      4'd4, 4'd13:         return "R8";
      default:             return "R9";
    endcase
  endfunction

  task automatic check(input string tag, input logic [64:0] exp);
    n_chk++;
    if ({out_bad, out_res} !== exp) begin
      n_err++;
      $display("FAIL %s: got bad=%0b res=%h, expected bad=%0b res=%h",
               tag, out_bad, out_res, exp[64], exp[63:0]);
    end
  endtask

  // Called at a falling edge; checks at the next falling edge.
  task automatic apply(input logic [3:0] op, input logic [4:0] saf, input logic [4:0] rsf,
                       input logic [63:0] rt, input logic [63:0] rs, input string tag);
    logic [64:0] exp;
    in_op = op; in_sa_fld = saf; in_rs_fld = rsf; in_rt = rt; in_rs = rs;
    exp = ref_op(op, saf, rsf, rt, rs);
    @(negedge clk);
    check((tag == "") ? tag_of(op, exp[64]) : tag, exp);
  endtask

  initial begin
    #2000000;
    n_err++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk + 1);
    $finish;
  end

  initial begin
    logic [63:0] pat;
    void'($urandom(32'h1f2e3d4c));
    pat = 64'h8123_4567_89ab_cdef;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1", 65'd0);
    rst = 1'b0;

    // R10: zero amounts
    apply(4'd6,  5'd0, 5'd0, pat, 64'd0, "R10");
    apply(4'd0,  5'd0, 5'd0, pat, 64'd0, "R10");
    apply(4'd1,  5'd0, 5'd1, pat, 64'd0, "R10");
    apply(4'd13, 5'd1, 5'd0, pat, 64'hffff_ffff_ffff_ffc0, "R10");
    // R3 rotate / shift word, sign extension
    apply(4'd1, 5'd4,  5'd1, 64'h0000_0000_1234_5678, 64'd0, "R3");
    apply(4'd1, 5'd31, 5'd0, 64'h0000_0000_8000_0000, 64'd0, "R3");
    apply(4'd1, 5'd1,  5'd1, 64'h0000_0000_0000_0001, 64'd0, "R3");
    // R6 +32 rotate and shift
    apply(4'd10, 5'd31, 5'd1, pat, 64'd0, "R6");
    apply(4'd10, 5'd0,  5'd0, pat, 64'd0, "R6");
    apply(4'd7,  5'd8,  5'd1, pat, 64'd0, "R6");
    // R5 / R7 +32 extremes
    apply(4'd9,  5'd31, 5'd0, 64'd1, 64'd0, "R5");
    apply(4'd11, 5'd31, 5'd0, pat, 64'd0, "R7");
    apply(4'd2,  5'd31, 5'd0, 64'h0000_0000_8000_0000, 64'd0, "R4");
    // R8 upper amount bits ignored
    apply(4'd4,  5'd1, 5'd0, 64'h0000_0000_0000_00f1, 64'hffff_ffff_ffff_ffe4, "R8");
    apply(4'd13, 5'd0, 5'd0, pat, 64'h1234_0000_0000_0044, "R8");
    apply(4'd3,  5'd0, 5'd0, 64'h0000_0000_0000_0003, 64'h0000_0000_0000_003f, "R2");
    // R9 illegal encodings, then recovery
    apply(4'd1,  5'd3, 5'd2,  pat, 64'd0, "R9");
    apply(4'd7,  5'd3, 5'd31, pat, 64'd0, "R9");
    apply(4'd10, 5'd3, 5'd5,  pat, 64'd0, "R9");
    apply(4'd15, 5'd0, 5'd0,  pat, 64'd0, "R9");
    apply(4'd6,  5'd4, 5'd9,  pat, 64'd0, "R9");

    for (int k = 0; k < 800; k++) begin
      logic [4:0] rsf;
      rsf = ($urandom_range(0, 5) == 0) ? 5'($urandom) : 5'($urandom_range(0, 1));
      apply(4'($urandom), 5'($urandom), rsf, {$urandom, $urandom}, {$urandom, $urandom}, "");
    end

    // R1: reset clears after activity
    in_op = 4'd6; in_sa_fld = 5'd0; in_rt = pat;
    rst = 1'b1;
    @(negedge clk);
    check("R1", 65'd0);
    rst = 1'b0;
    apply(4'd8, 5'd4, 5'd0, pat, 64'd0, "R1");

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule